// File: doc/BRIEF.md
# Sleep Mode Controller

This block sits between a small processor core and the clock and interrupt logic that surround it, and manages the core's low-power sleep. Software picks a sleep mode with a 3-bit mode field and arms a sleep-enable bit. The core sends a one-cycle pulse when it executes its sleep instruction. The controller then stops the selected clock domains and holds the core halted until a legal wake source fires. It then waits a start-up delay that depends on the mode and keeps the core halted for four more cycles. Last, it tells the core to go to its interrupt routine.

The six modes differ in two ways: which clocks stay running, and which interrupt sources may end the sleep. In every mode except Idle, the two external interrupt lines wake the core only when they are configured for level sensing. The asynchronous timer wakes the core from the timer-keeping modes only while it runs from its own clock. A reset during sleep returns the controller to its running state on the next edge, and the controller reports that the core must start from its reset vector.

Top module: `sleep_ctrl`

## Requirements
- R1: Sleep starts only on an edge where `sleep_instr` and `sleep_en` are both 1. On the next cycle `cpu_halt` is 1. A `sleep_instr` pulse with `sleep_en` at 0, or `sleep_en` at 1 with no pulse, leaves `cpu_halt` at 0 and all five clock enables at 1.
- R2: While asleep, the enables {cpu, io, adc, atmr, osc} equal, by `sleep_mode` code: 000 Idle 01111, 001 ADC noise reduction 00111, 010 power-down 00000, 011 power-save 00010, 110 standby 00001, 111 extended standby 00011. The codes 100 and 101 act as Idle. In the running state all enables are 1.
- R3: Wake sources are bit-indexed in `irq_req`/`irq_en`: 0 ext0, 1 ext1, 2 pin change, 3 serial-address match, 4 async timer, 5 watchdog, 6 ADC, 7 other I/O. A wake needs a bit that is requested, enabled and legal for the mode. Bit 7 is legal only in Idle. Bit 6 is legal only in Idle and ADC noise reduction. Bits 2, 3 and 5 are legal in all modes.
- R4: Outside Idle, bit 0 (or bit 1) wakes only if `ext_level[0]` (or `ext_level[1]`) is 1. In Idle they always wake.
- R5: Bit 4 wakes in Idle always, in ADC noise reduction, power-save and extended standby only while `atmr_async` is 1, and never in power-down or standby.
- R6: Let E0 be the edge that sees the wake. Let D be 0 for Idle and ADC noise reduction, OSC_DLY for power-down and power-save, and STBY_DLY for standby and extended standby. Then `cpu_halt` falls after edge E0+D+4. While D cycles of start-up run, `osc_en` is 1 and the other enables keep their sleep values.
- R7: During the four post-start-up halt cycles, `cpu_halt` is 1, `clk_en_cpu` is 0 and the other four enables are 1.
- R8: After an interrupt wake, `wake_irq` is 1 for exactly the first running cycle, and `wake_rst` stays 0.
- R9: A `rst` sampled during sleep makes the next cycle running: `cpu_halt` 0, all enables 1, `wake_rst` 1 and `wake_irq` 0.
- R10: The mode is captured when sleep starts. Changes to `sleep_mode`, and further `sleep_instr` pulses while asleep, do not change the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Sleep enable bit from the control register |
| sleep_mode | input | 3 | Mode field from the control register |
| sleep_instr | input | 1 | One-cycle pulse: sleep instruction executed |
| irq_req | input | 8 | Interrupt requests, one per wake source |
| irq_en | input | 8 | Interrupt enables, one per wake source |
| ext_level | input | 2 | External interrupt 0/1 configured as level-sensed |
| atmr_async | input | 1 | Async timer running from its own clock |
| clk_en_cpu | output | 1 | CPU clock gate enable |
| clk_en_io | output | 1 | I/O clock gate enable |
| clk_en_adc | output | 1 | ADC clock gate enable |
| clk_en_atmr | output | 1 | Async timer clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| cpu_halt | output | 1 | Core halted |
| wake_irq | output | 1 | Pulse: resume through the interrupt routine |
| wake_rst | output | 1 | Pulse: restart at the reset vector |

## Verification
Every output is registered, so the enables and `cpu_halt` show the sleep state one edge after the entry pulse, and a reset during sleep is visible one edge later. After the wake edge, `cpu_halt` stays high through D+4 further edges, where D depends on the mode. `wake_irq` is high in the cycle that follows those edges and low again one edge later. The bench drives and samples only at falling edges. It counts falling edges from the one where the wake request is raised: it checks the start-up enables at count D, the halt enables at D+1, `cpu_halt` still high at D+4, and the release together with the `wake_irq` pulse at D+5. A source that must not wake is held for several cycles, and the bench then checks that `cpu_halt` and the enables have not moved.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int NSRC        = 8;
    localparam int SRC_EXT0    = 0;
    localparam int SRC_EXT1    = 1;
    localparam int SRC_PCHG    = 2;
    localparam int SRC_TWI     = 3;
    localparam int SRC_ATMR    = 4;
    localparam int SRC_WDT     = 5;
    localparam int SRC_ADC     = 6;
    localparam int SRC_IO      = 7;
    localparam int HALT_CYCLES = 4;

    // Encodings are software visible through the control register.
    typedef enum logic [2:0] {
        MD_IDLE  = 3'b000,
        MD_ADCNR = 3'b001,
        MD_PDOWN = 3'b010,
        MD_PSAVE = 3'b011,
        MD_STBY  = 3'b110,
        MD_ESTBY = 3'b111
    } slp_mode_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic atmr;
        logic osc;
    } gate_t;

    localparam gate_t GATES_ON = 5'b11111;

    function automatic gate_t sleep_gates(slp_mode_e m);
        gate_t g;
        case (m)
            MD_IDLE:  g = 5'b01111;
            MD_ADCNR: g = 5'b00111;
            MD_PDOWN: g = 5'b00000;
            MD_PSAVE: g = 5'b00010;
            MD_STBY:  g = 5'b00001;
            MD_ESTBY: g = 5'b00011;
            default:  g = 5'b01111;
        endcase
        return g;
    endfunction

    function automatic logic [NSRC-1:0] legal_wake(slp_mode_e m, logic [1:0] lvl, logic async_clk);
        logic [NSRC-1:0] r;
        logic idle;
        idle          = (m == MD_IDLE);
        r             = '0;
        r[SRC_EXT0]   = idle | lvl[0];
        r[SRC_EXT1]   = idle | lvl[1];
        r[SRC_PCHG]   = 1'b1;
        r[SRC_TWI]    = 1'b1;
        r[SRC_WDT]    = 1'b1;
        r[SRC_ATMR]   = idle | (async_clk & ((m == MD_ADCNR) | (m == MD_PSAVE) | (m == MD_ESTBY)));
        r[SRC_ADC]    = idle | (m == MD_ADCNR);
        r[SRC_IO]     = idle;
        return r;
    endfunction

endpackage

// File: rtl/slp_mode_dec.sv
module slp_mode_dec
    import slp_pkg::*;
(
    input  logic [2:0] raw_mode,
    output slp_mode_e  mode
);
    always_comb begin
        case (raw_mode)
            3'b001:  mode = MD_ADCNR;
            3'b010:  mode = MD_PDOWN;
            3'b011:  mode = MD_PSAVE;
            3'b110:  mode = MD_STBY;
            3'b111:  mode = MD_ESTBY;
            default: mode = MD_IDLE;   // 000 and reserved 100/101
        endcase
    end
endmodule

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
    import slp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  slp_mode_e       mode,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic [1:0]      ext_level,
    input  logic            atmr_async,
    output logic            wake_hit
);
    logic [NSRC-1:0] legal;
    logic [NSRC-1:0] pending;

    assign legal    = legal_wake(mode, ext_level, atmr_async);
    assign pending  = irq_req & irq_en;
    assign wake_hit = |(pending & legal);

    AST_WAKE_NEEDS_ENABLED_REQ: assert property (@(posedge clk) disable iff (rst)
        wake_hit |-> ((irq_req & irq_en) != '0));  // R3
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int OSC_DLY  = 16,
    parameter int STBY_DLY = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_en,
    input  logic      sleep_instr,
    input  slp_mode_e mode_in,
    input  logic      wake_hit,
    output slp_mode_e mode_q,
    output gate_t     gates,
    output logic      cpu_halt,
    output logic      wake_irq,
    output logic      wake_rst
);
    localparam int MAXC = (OSC_DLY > STBY_DLY) ?
                          ((OSC_DLY > HALT_CYCLES) ? OSC_DLY : HALT_CYCLES) :
                          ((STBY_DLY > HALT_CYCLES) ? STBY_DLY : HALT_CYCLES);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HALT_LOAD = CW'(HALT_CYCLES - 1);

    typedef enum logic [1:0] {ST_ACTIVE, ST_SLEEP, ST_STARTUP, ST_HALT} st_e;

    st_e       st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    slp_mode_e mode_n;
    gate_t     gates_n;
    logic      irq_n;

    function automatic logic [CW-1:0] startup_len(slp_mode_e m);
        case (m)
            MD_PDOWN, MD_PSAVE: return CW'(OSC_DLY);
            MD_STBY,  MD_ESTBY: return CW'(STBY_DLY);
            default:            return '0;
        endcase
    endfunction

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        mode_n = mode_q;
        irq_n  = 1'b0;
        case (st)
            ST_ACTIVE: if (sleep_instr && sleep_en) begin
                st_n   = ST_SLEEP;
                mode_n = mode_in;
            end
            ST_SLEEP: if (wake_hit) begin
                if (startup_len(mode_q) == '0) begin
                    st_n  = ST_HALT;
                    cnt_n = HALT_LOAD;
                end else begin
                    st_n  = ST_STARTUP;
                    cnt_n = startup_len(mode_q) - CW'(1);
                end
            end
            ST_STARTUP: if (cnt == '0) begin
                st_n  = ST_HALT;
                cnt_n = HALT_LOAD;
            end else begin
                cnt_n = cnt - CW'(1);
            end
            ST_HALT: if (cnt == '0) begin
                st_n  = ST_ACTIVE;
                irq_n = 1'b1;
            end else begin
                cnt_n = cnt - CW'(1);
            end
            default: st_n = ST_ACTIVE;
        endcase

        case (st_n)
            ST_SLEEP:   gates_n = sleep_gates(mode_n);
            ST_STARTUP: begin
                gates_n     = sleep_gates(mode_n);
                gates_n.osc = 1'b1;
            end
            ST_HALT: begin
                gates_n     = GATES_ON;
                gates_n.cpu = 1'b0;
            end
            default:    gates_n = GATES_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_rst <= (st != ST_ACTIVE);
            st       <= ST_ACTIVE;
            cnt      <= '0;
            mode_q   <= MD_IDLE;
            gates    <= GATES_ON;
            cpu_halt <= 1'b0;
            wake_irq <= 1'b0;
        end else begin
            wake_rst <= 1'b0;
            st       <= st_n;
            cnt      <= cnt_n;
            mode_q   <= mode_n;
            gates    <= gates_n;
            cpu_halt <= (st_n != ST_ACTIVE);
            wake_irq <= irq_n;
        end
    end

    AST_HALT_GATES_CPU: assert property (@(posedge clk) disable iff (rst)
        cpu_halt |-> !gates.cpu);  // R7
    AST_HALT_LEN_END: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HALT && cnt == '0) |=> (!cpu_halt && wake_irq));  // R6
    AST_MODE_HELD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SLEEP) |=> $stable(mode_q));  // R10
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import slp_pkg::*;
#(
    parameter int OSC_DLY  = 16,
    parameter int STBY_DLY = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sleep_en,
    input  logic [2:0]      sleep_mode,
    input  logic            sleep_instr,
    input  logic [NSRC-1:0] irq_req,
    input  logic [NSRC-1:0] irq_en,
    input  logic [1:0]      ext_level,
    input  logic            atmr_async,
    output logic            clk_en_cpu,
    output logic            clk_en_io,
    output logic            clk_en_adc,
    output logic            clk_en_atmr,
    output logic            osc_en,
    output logic            cpu_halt,
    output logic            wake_irq,
    output logic            wake_rst
);
    slp_mode_e mode_dec;
    slp_mode_e mode_q;
    gate_t     gates;
    logic      wake_hit;

    slp_mode_dec u_dec (
        .raw_mode (sleep_mode),
        .mode     (mode_dec)
    );

    slp_wake_qual u_wake (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_q),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .ext_level  (ext_level),
        .atmr_async (atmr_async),
        .wake_hit   (wake_hit)
    );

    slp_fsm #(.OSC_DLY(OSC_DLY), .STBY_DLY(STBY_DLY)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_en    (sleep_en),
        .sleep_instr (sleep_instr),
        .mode_in     (mode_dec),
        .wake_hit    (wake_hit),
        .mode_q      (mode_q),
        .gates       (gates),
        .cpu_halt    (cpu_halt),
        .wake_irq    (wake_irq),
        .wake_rst    (wake_rst)
    );

    assign clk_en_cpu  = gates.cpu;
    assign clk_en_io   = gates.io;
    assign clk_en_adc  = gates.adc;
    assign clk_en_atmr = gates.atmr;
    assign osc_en      = gates.osc;

    AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (!cpu_halt && !(sleep_instr && sleep_en)) |=> !cpu_halt);  // R1
    AST_IRQ_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq);  // R8
    AST_IRQ_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> ($past(cpu_halt) && !cpu_halt && !wake_rst));  // R8
    AST_RST_WAKE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        wake_rst |-> (!cpu_halt && !wake_irq && clk_en_cpu && osc_en));  // R9
endmodule

// File: tb/sleep_ctrl_test.sv
module sleep_ctrl_test;
    localparam int OSC_D  = 12;
    localparam int STBY_D = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       sleep_en;
    logic [2:0] sleep_mode;
    logic       sleep_instr;
    logic [7:0] irq_req;
    logic [7:0] irq_en;
    logic [1:0] ext_level;
    logic       atmr_async;
    logic       clk_en_cpu, clk_en_io, clk_en_adc, clk_en_atmr, osc_en;
    logic       cpu_halt, wake_irq, wake_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sleep_ctrl #(.OSC_DLY(OSC_D), .STBY_DLY(STBY_D)) uut (
        .clk(clk), .rst(rst), .sleep_en(sleep_en), .sleep_mode(sleep_mode),
        .sleep_instr(sleep_instr), .irq_req(irq_req), .irq_en(irq_en),
        .ext_level(ext_level), .atmr_async(atmr_async),
        .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io), .clk_en_adc(clk_en_adc),
        .clk_en_atmr(clk_en_atmr), .osc_en(osc_en), .cpu_halt(cpu_halt),
        .wake_irq(wake_irq), .wake_rst(wake_rst)
    );

    function automatic logic [4:0] gv();
        return {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_atmr, osc_en};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic enter(logic [2:0] md);
        sleep_en    = 1'b1;
        sleep_mode  = md;
        sleep_instr = 1'b1;
        tick(1);
        sleep_instr = 1'b0;
    endtask

    // Raise source, follow start-up and halt windows, check release.
    task automatic wake_seq(int src, int d, logic [4:0] slp_g, string req);
        irq_en[src]  = 1'b1;
        irq_req[src] = 1'b1;
        for (int i = 1; i <= d + 4; i++) begin
            tick(1);
            if (d > 0 && i == d) chk("R6", {req, " startup gates"}, gv(), slp_g | 5'b00001);
            if (i == d + 1) begin
                chk("R7", {req, " halt gates"}, gv(), 5'b01111);
                chk("R7", {req, " halt"}, cpu_halt, 1);
            end
        end
        irq_req = '0;
        chk("R6", {req, " still halted at D+4"}, cpu_halt, 1);
        tick(1);
        chk("R6", {req, " released at D+5"}, cpu_halt, 0);
        chk("R8", {req, " wake_irq pulse"}, wake_irq, 1);
        chk("R8", {req, " no wake_rst"}, wake_rst, 0);
        chk("R2", {req, " running gates"}, gv(), 5'b11111);
        tick(1);
        chk("R8", {req, " pulse one cycle"}, wake_irq, 0);
        irq_en = '0;
    endtask

    task automatic t_reset;
        rst = 1'b1; sleep_en = 0; sleep_mode = 0; sleep_instr = 0;
        irq_req = '0; irq_en = '0; ext_level = '0; atmr_async = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1", "reset halt", cpu_halt, 0);
        chk("R2", "reset gates", gv(), 5'b11111);
        chk("R8", "reset wake_irq", wake_irq, 0);
        chk("R9", "reset wake_rst", wake_rst, 0);
    endtask

    task automatic t_noop;
        sleep_en = 1'b0; sleep_mode = 3'b010; sleep_instr = 1'b1;
        tick(1);
        sleep_instr = 1'b0;
        tick(1);
        chk("R1", "instr without enable", cpu_halt, 0);
        chk("R1", "instr without enable gates", gv(), 5'b11111);
        sleep_en = 1'b1;
        tick(3);
        chk("R1", "enable without instr", cpu_halt, 0);
        sleep_en = 1'b0;
    endtask

    task automatic t_idle;
        enter(3'b000);
        chk("R1", "idle entered", cpu_halt, 1);
        chk("R2", "idle gates", gv(), 5'b01111);
        irq_en[7] = 1'b1;   // not requested
        tick(3);
        chk("R3", "enabled but not requested", cpu_halt, 1);
        irq_req[0] = 1'b1;  // requested but not enabled
        irq_en     = '0;
        tick(3);
        chk("R3", "requested not enabled", cpu_halt, 1);
        irq_req = '0;
        wake_seq(7, 0, 5'b01111, "idle io");
    endtask

    task automatic t_reserved;
        enter(3'b101);
        chk("R2", "reserved 101 as idle", gv(), 5'b01111);
        wake_seq(0, 0, 5'b01111, "reserved ext0 edge");   // R4: edge ok in idle
        enter(3'b100);
        chk("R2", "reserved 100 as idle", gv(), 5'b01111);
        wake_seq(4, 0, 5'b01111, "reserved atmr sync");   // R5: idle always
    endtask

    task automatic t_adcnr;
        enter(3'b001);
        chk("R2", "adcnr gates", gv(), 5'b00111);
        irq_en[7] = 1'b1; irq_req[7] = 1'b1;
        tick(4);
        chk("R3", "io ignored in adcnr", cpu_halt, 1);
        chk("R3", "io ignored gates", gv(), 5'b00111);
        irq_req = '0; irq_en = '0;
        wake_seq(6, 0, 5'b00111, "adcnr adc");
    endtask

    task automatic t_pdown;
        enter(3'b010);
        chk("R2", "pdown gates", gv(), 5'b00000);
        irq_en = 8'hC0; irq_req = 8'hC0;   // adc + io
        tick(4);
        chk("R3", "adc/io ignored in pdown", cpu_halt, 1);
        irq_en = 8'h01; irq_req = 8'h01; ext_level = 2'b00;
        tick(4);
        chk("R4", "ext0 edge ignored", cpu_halt, 1);
        chk("R4", "ext0 edge gates", gv(), 5'b00000);
        irq_en = 8'h10; irq_req = 8'h10; atmr_async = 1'b1;
        tick(4);
        chk("R5", "atmr ignored in pdown", cpu_halt, 1);
        irq_en = '0; irq_req = '0; atmr_async = 1'b0;
        ext_level = 2'b10;
        wake_seq(1, OSC_D, 5'b00000, "pdown ext1 level");
        ext_level = 2'b00;
    endtask

    task automatic t_psave;
        enter(3'b011);
        chk("R2", "psave gates", gv(), 5'b00010);
        irq_en[4] = 1'b1; irq_req[4] = 1'b1; atmr_async = 1'b0;
        tick(4);
        chk("R5", "atmr sync ignored", cpu_halt, 1);
        irq_req = '0; irq_en = '0;
        atmr_async = 1'b1;
        wake_seq(4, OSC_D, 5'b00010, "psave atmr async");
        atmr_async = 1'b0;
    endtask

    task automatic t_stby;
        enter(3'b110);
        chk("R2", "stby gates", gv(), 5'b00001);
        irq_en[4] = 1'b1; irq_req[4] = 1'b1; atmr_async = 1'b1;
        tick(4);
        chk("R5", "atmr ignored in stby", cpu_halt, 1);
        irq_req = '0; irq_en = '0; atmr_async = 1'b0;
        wake_seq(5, STBY_D, 5'b00001, "stby wdt");
        enter(3'b111);
        chk("R2", "estby gates", gv(), 5'b00011);
        wake_seq(2, STBY_D, 5'b00011, "estby pinchg");
    endtask

    task automatic t_latch;
        enter(3'b010);
        sleep_mode = 3'b000;
        tick(2);
        chk("R10", "mode change ignored", gv(), 5'b00000);
        sleep_instr = 1'b1;
        tick(1);
        sleep_instr = 1'b0;
        tick(1);
        chk("R10", "second instr ignored", gv(), 5'b00000);
        irq_en[7] = 1'b1; irq_req[7] = 1'b1;
        tick(3);
        chk("R10", "io still illegal", cpu_halt, 1);
        irq_req = '0; irq_en = '0;
        wake_seq(3, OSC_D, 5'b00000, "latched pdown twi");
    endtask

    task automatic t_rst_sleep;
        enter(3'b011);
        chk("R9", "asleep before reset", cpu_halt, 1);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk("R9", "reset wake halt", cpu_halt, 0);
        chk("R9", "reset wake gates", gv(), 5'b11111);
        chk("R9", "reset wake flag", wake_rst, 1);
        chk("R9", "reset no irq flag", wake_irq, 0);
        tick(1);
        chk("R9", "reset flag clears", wake_rst, 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(1);
        t_reset();
        t_noop();
        t_idle();
        t_reserved();
        t_adcnr();
        t_pdown();
        t_psave();
        t_stby();
        t_latch();
        t_rst_sleep();
        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule